// File: doc/BRIEF.md
# Subtract-with-Borrow Instruction Sequencer

This block carries out a single 8-bit subtract-with-borrow instruction for an accumulator-style datapath. After a one-cycle `start` pulse, it fetches the opcode at `pc_in` from a byte-wide synchronous memory. It then fetches the operand bytes the opcode needs and resolves the effective address using one of eight addressing modes. The index values used in address arithmetic come from `x_in` and `y_in`. It reads the operand and subtracts it from the accumulator, with the incoming carry acting as an inverted borrow. The block then raises `done` for one cycle. On that same cycle the new accumulator and the negative, zero, carry and overflow flags appear on the outputs.

The memory returns the byte addressed while `mem_rd_en` is high on the next clock cycle. The register and flag inputs are sampled on the cycle that `start` is accepted, so the surrounding datapath may change them while the instruction runs. An opcode outside the supported set ends the instruction at once. It sets `done` and `illegal`, and the outputs reload the register values given at start without any arithmetic. Only binary arithmetic is performed.

Top module: `sbc_exec`

## Requirements
- R1: The opcode byte selects the mode: 0xE9 immediate, 0xE5 zero page, 0xF5 zero page plus X, 0xED absolute, 0xFD absolute plus X, 0xF9 absolute plus Y, 0xE1 indirect through (zero page plus X), 0xF1 indirect then plus Y. Any other opcode gives `done` and `illegal` together for one cycle, with one memory read in total. `a_out` and the four flag outputs then equal the values given with `start`.
- R2: The result is A − M − (1 − C) modulo 256. Carry out is 1 exactly when the true difference is not negative.
- R3: N equals bit 7 of the result, and Z is 1 exactly when the 8-bit result is zero.
- R4: V is 1 exactly when the signed difference falls outside −128..127. Equivalently, A and M have different signs and the result's sign differs from A's sign.
- R5: In immediate mode the byte after the opcode is the operand. `done` rises 3 clock edges after the edge that accepts `start`, counting that edge as the first.
- R6: Zero-page mode reads the operand at the byte after the opcode. Zero-page-plus-X mode reads it at (that byte + X) mod 256. `done` comes on the 4th edge.
- R7: Absolute modes take a 16-bit little-endian address from the two bytes after the opcode. The plus-X and plus-Y modes add that index modulo 65536. `done` comes on the 5th edge.
- R8: The indirect-X mode forms p = (operand + X) mod 256. It reads the pointer low byte at p and the high byte at (p + 1) mod 256, and uses the pointer as the effective address. `done` comes on the 6th edge.
- R9: The indirect-Y mode reads the pointer at the operand byte p and at (p + 1) mod 256. It adds Y modulo 65536 to form the effective address. `done` comes on the 6th edge.
- R10: `done` is a one-cycle pulse, and `a_out` and the flags change only on a cycle with `done` high. A `start` arriving while an instruction runs is ignored, and input changes after acceptance do not affect the result.
- R11: After reset, `done`, `illegal` and `mem_rd_en` are 0, and `a_out` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one instruction when idle |
| pc_in | input | 16 | Address of the opcode byte |
| a_in | input | 8 | Accumulator value at start |
| x_in | input | 8 | X index value at start |
| y_in | input | 8 | Y index value at start |
| n_in | input | 1 | Negative flag at start |
| z_in | input | 1 | Zero flag at start |
| c_in | input | 1 | Carry flag at start (1 = no borrow) |
| v_in | input | 1 | Overflow flag at start |
| mem_addr | output | 16 | Memory read address |
| mem_rd_en | output | 1 | Memory read request |
| mem_rdata | input | 8 | Byte read, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unsupported opcode, pulses with done |
| a_out | output | 8 | Accumulator after the instruction |
| n_out | output | 1 | Negative flag after the instruction |
| z_out | output | 1 | Zero flag after the instruction |
| c_out | output | 1 | Carry flag after the instruction |
| v_out | output | 1 | Overflow flag after the instruction |

## Verification
The hardest situations to reach are the address wraps hidden inside the multi-read modes. These are a zero-page pointer whose high byte sits at 0x00 after a low byte at 0xFF, a zero-page index sum that passes 0xFF, and an indexed absolute sum that passes 0xFFFF. The stimulus places the operand bytes and pointers at exactly those addresses. The bench's memory model logs every read, so both the data and the full sequence of addresses are compared against a behavioural prediction. A second start pulse, together with changed index and accumulator inputs, is injected in the middle of a running instruction to show that the captured values are used.

// File: rtl/sbc_pkg.sv
// Shared types for the subtract-with-borrow sequencer.
// Assumes byte-wide data and a 16-bit address built from two data bytes.
package sbc_pkg;

    // Addressing mode decoded from the opcode byte
    typedef enum logic [3:0] {
        AM_IMM,
        AM_ZP,
        AM_ZPX,
        AM_ABS,
        AM_ABSX,
        AM_ABSY,
        AM_INDX,
        AM_INDY,
        AM_NONE
    } addr_mode_e;

    // Sequencer state; each state names the byte arriving on mem_rdata
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_BYTE1,
        ST_BYTE2,
        ST_PTRHI,
        ST_DATA
    } seq_state_e;

    // Status flags carried as one unit
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/sbc_decode.sv
// Opcode decoder: maps an opcode byte to its addressing mode.
// Assumes the opcode is 8 bits; anything unlisted is reported not legal.
module sbc_decode
    import sbc_pkg::*;
(
    input  logic [7:0]  opcode,
    output addr_mode_e  mode,
    output logic        legal
);

    // Map the opcode onto one of the eight modes
    always_comb begin
        legal = 1'b1;
        case (opcode)
            8'hE9:   mode = AM_IMM;
            8'hE5:   mode = AM_ZP;
            8'hF5:   mode = AM_ZPX;
            8'hED:   mode = AM_ABS;
            8'hFD:   mode = AM_ABSX;
            8'hF9:   mode = AM_ABSY;
            8'hE1:   mode = AM_INDX;
            8'hF1:   mode = AM_INDY;
            default: begin
                mode  = AM_NONE;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sbc_alu.sv
// Binary subtract-with-borrow unit: res = a - m - (1 - c_in), with flags.
// Purely combinational; carry in/out follow the inverted-borrow rule.
module sbc_alu
    import sbc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output flags_t        flags
);

    localparam int XW = DW + 1;

    logic [XW-1:0] diff;

    // Extended subtraction; the top bit is the borrow out
    always_comb begin
        diff = {1'b0, a} - {1'b0, m} - XW'(!c_in);
        res  = diff[DW-1:0];
    end

    // Flag generation from operands and result
    always_comb begin
        flags.n = res[DW-1];
        flags.z = (res == '0);
        flags.c = !diff[XW-1];
        flags.v = (a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ res[DW-1]);
    end

    // Relations between operands and flags
    always_comb begin
        if (!$isunknown({a, m, c_in})) begin
            // R4
            same_sign_no_ovf_chk: assert ((a[DW-1] != m[DW-1]) || !flags.v);
            // R2
            no_borrow_keep_chk: assert (!(c_in && m == '0) || (flags.c && res == a));
        end
    end

endmodule

// File: rtl/sbc_seq.sv
// Fetch and address sequencer: issues the opcode, operand, pointer and data
// reads for one instruction and flags the cycle on which the operand byte is
// present on mem_rdata. Assumes a read returns data the cycle after request
// and that AW equals two data bytes.
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] mem_rdata,
    input  addr_mode_e    dec_mode,
    input  logic          dec_legal,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    output logic          accept,
    output logic          consume,
    output logic          bad_op
);

    localparam int PW = 2 * DW;

    seq_state_e    state, state_nx;
    addr_mode_e    mode_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q, y_q;
    logic [DW-1:0] zp_q;
    logic [DW-1:0] lo_q;

    logic [DW-1:0] zp_base_w;
    logic [DW-1:0] zp_next_w;
    logic [DW-1:0] idx_w;
    logic [DW-1:0] lo_sel_w;
    logic [AW-1:0] eff_w;

    // Index and address arithmetic shared by all modes
    always_comb begin
        zp_base_w = ((mode_q == AM_ZPX) || (mode_q == AM_INDX)) ? mem_rdata + x_q : mem_rdata;
        zp_next_w = zp_q + DW'(1);
        case (mode_q)
            AM_ABSX:          idx_w = x_q;
            AM_ABSY, AM_INDY: idx_w = y_q;
            default:          idx_w = '0;
        endcase
        lo_sel_w = (state == ST_PTRHI) ? lo_q : zp_q;
        eff_w    = AW'(PW'({mem_rdata, lo_sel_w})) + AW'(idx_w);
    end

    // Next state, read request and address per state
    always_comb begin
        state_nx  = state;
        mem_rd_en = 1'b0;
        mem_addr  = pc_in;
        accept    = 1'b0;
        consume   = 1'b0;
        bad_op    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    mem_rd_en = 1'b1;
                    state_nx  = ST_OPC;
                end
            end
            ST_OPC: begin
                if (!dec_legal) begin
                    bad_op   = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    mem_rd_en = 1'b1;
                    mem_addr  = pc_q + AW'(1);
                    state_nx  = ST_BYTE1;
                end
            end
            ST_BYTE1: begin
                case (mode_q)
                    AM_IMM: begin
                        consume  = 1'b1;
                        state_nx = ST_IDLE;
                    end
                    AM_ZP, AM_ZPX, AM_INDX, AM_INDY: begin
                        mem_rd_en = 1'b1;
                        mem_addr  = AW'(zp_base_w);
                        state_nx  = ST_BYTE2;
                    end
                    default: begin
                        mem_rd_en = 1'b1;
                        mem_addr  = pc_q + AW'(2);
                        state_nx  = ST_BYTE2;
                    end
                endcase
            end
            ST_BYTE2: begin
                case (mode_q)
                    AM_ZP, AM_ZPX: begin
                        consume  = 1'b1;
                        state_nx = ST_IDLE;
                    end
                    AM_INDX, AM_INDY: begin
                        mem_rd_en = 1'b1;
                        mem_addr  = AW'(zp_next_w);
                        state_nx  = ST_PTRHI;
                    end
                    default: begin
                        mem_rd_en = 1'b1;
                        mem_addr  = eff_w;
                        state_nx  = ST_DATA;
                    end
                endcase
            end
            ST_PTRHI: begin
                mem_rd_en = 1'b1;
                mem_addr  = eff_w;
                state_nx  = ST_DATA;
            end
            ST_DATA: begin
                consume  = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and per-instruction captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= AM_NONE;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            zp_q   <= '0;
            lo_q   <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                pc_q <= pc_in;
                x_q  <= x_in;
                y_q  <= y_in;
            end
            if (state == ST_OPC) mode_q <= dec_mode;
            if (state == ST_BYTE1) zp_q <= zp_base_w;
            if (state == ST_BYTE2) lo_q <= mem_rdata;
        end
    end

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(pc_q) && $stable(x_q) && $stable(y_q));

    // R10
    read_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (state != ST_IDLE));

endmodule

// File: rtl/sbc_exec.sv
// Top of the subtract-with-borrow executor. Captures the accumulator and
// flags on start, lets the sequencer fetch the operand, and commits the
// result and flags together with a one-cycle done pulse. An unsupported
// opcode commits the captured values unchanged and pulses illegal.
module sbc_exec
    import sbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic          n_in,
    input  logic          z_in,
    input  logic          c_in,
    input  logic          v_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] a_out,
    output logic          n_out,
    output logic          z_out,
    output logic          c_out,
    output logic          v_out
);

    addr_mode_e    dec_mode;
    logic          dec_legal;
    logic          accept, consume, bad_op;
    logic [DW-1:0] a_w;
    flags_t        f_w;
    logic [DW-1:0] alu_res;
    flags_t        alu_flags;
    logic [DW-1:0] a_q;
    flags_t        f_q;
    logic          done_q, illegal_q;

    sbc_decode u_decode (
        .opcode (mem_rdata[7:0]),
        .mode   (dec_mode),
        .legal  (dec_legal)
    );

    sbc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .mem_rdata (mem_rdata),
        .dec_mode  (dec_mode),
        .dec_legal (dec_legal),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .accept    (accept),
        .consume   (consume),
        .bad_op    (bad_op)
    );

    sbc_alu #(.DW(DW)) u_alu (
        .a     (a_w),
        .m     (mem_rdata),
        .c_in  (f_w.c),
        .res   (alu_res),
        .flags (alu_flags)
    );

    // Capture accumulator and flags when an instruction is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_w <= '0;
            f_w <= '0;
        end else if (accept) begin
            a_w <= a_in;
            f_w <= '{n: n_in, z: z_in, c: c_in, v: v_in};
        end
    end

    // Commit result or captured values with the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q       <= '0;
            f_q       <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= consume | bad_op;
            illegal_q <= bad_op;
            if (consume) begin
                a_q <= alu_res;
                f_q <= alu_flags;
            end else if (bad_op) begin
                a_q <= a_w;
                f_q <= f_w;
            end
        end
    end

    assign done    = done_q;
    assign illegal = illegal_q;
    assign a_out   = a_q;
    assign n_out   = f_q.n;
    assign z_out   = f_q.z;
    assign c_out   = f_q.c;
    assign v_out   = f_q.v;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R1
    illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> done_q);

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_q) |-> done_q);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q) |-> done_q);

endmodule

// File: tb/tb_sbc_exec.sv
// Bench: behavioural memory with a read log, a behavioural model of the
// effective address, read sequence, latency and arithmetic, compared at
// every falling edge.
module tb_sbc_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  a_in = '0, x_in = '0, y_in = '0;
    logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata = '0;
    logic        done, illegal;
    logic [7:0]  a_out;
    logic        n_out, z_out, c_out, v_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] mem [int];
    int         rd_log [$];

    always #2 clk = ~clk;

    sbc_exec dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
        .a_in(a_in), .x_in(x_in), .y_in(y_in),
        .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal), .a_out(a_out),
        .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
    );

    function automatic logic [7:0] rd(int addr);
        return mem.exists(addr) ? mem[addr] : 8'h00;
    endfunction

    // Synchronous memory model with a log of requested addresses
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= rd(int'(mem_addr));
            rd_log.push_back(int'(mem_addr));
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one instruction and compare against the behavioural model
    task automatic run_case(input string req, input int pc, input int a, input int x, input int y,
                            input int cf, input int fl_n, input int fl_z, input int fl_v,
                            input bit poke);
        int op, b1, b2, p, eff, m, lat, diff, sa, sm, sres, res;
        int exp_reads [$];
        bit bad;
        int e;
        op = rd(pc); b1 = rd((pc + 1) % 65536); b2 = rd((pc + 2) % 65536);
        bad = 1'b0; eff = 0; lat = 0;
        exp_reads.push_back(pc);
        case (op)
            'hE9: begin lat = 2; eff = (pc + 1) % 65536; exp_reads.push_back(eff); end
            'hE5, 'hF5: begin
                lat = 3; eff = (op == 'hF5) ? (b1 + x) % 256 : b1;
                exp_reads.push_back((pc + 1) % 65536); exp_reads.push_back(eff);
            end
            'hED, 'hFD, 'hF9: begin
                lat = 4; eff = b1 + 256 * b2;
                if (op == 'hFD) eff = (eff + x) % 65536;
                if (op == 'hF9) eff = (eff + y) % 65536;
                exp_reads.push_back((pc + 1) % 65536); exp_reads.push_back((pc + 2) % 65536);
                exp_reads.push_back(eff);
            end
            'hE1, 'hF1: begin
                lat = 5; p = (op == 'hE1) ? (b1 + x) % 256 : b1;
                eff = rd(p) + 256 * rd((p + 1) % 256);
                if (op == 'hF1) eff = (eff + y) % 65536;
                exp_reads.push_back((pc + 1) % 65536); exp_reads.push_back(p);
                exp_reads.push_back((p + 1) % 256); exp_reads.push_back(eff);
            end
            default: begin lat = 1; bad = 1'b1; end
        endcase
        m    = rd(eff);
        diff = a - m - (1 - cf);
        res  = (diff + 256) % 256;
        sa   = (a >= 128) ? a - 256 : a;
        sm   = (m >= 128) ? m - 256 : m;
        sres = sa - sm - (1 - cf);

        rd_log.delete();
        @(negedge clk);
        pc_in = 16'(pc); a_in = 8'(a); x_in = 8'(x); y_in = 8'(y);
        c_in = cf[0]; n_in = fl_n[0]; z_in = fl_z[0]; v_in = fl_v[0];
        start = 1'b1;
        @(posedge clk);
        e = 1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (poke && e == 2) begin
                start = 1'b1; pc_in = 16'h0300; a_in = ~8'(a); x_in = 8'(x + 7); y_in = 8'(y + 9);
                c_in = ~cf[0];
            end else if (poke && e == 3) begin
                start = 1'b0;
            end
            check(req, "done timing", int'(done), int'(e == lat + 1));
            if (e >= lat + 1) break;
            @(posedge clk);
            e++;
            @(negedge clk);
        end
        start = 1'b0;
        check(req, "illegal", int'(illegal), int'(bad));
        if (bad) begin
            check(req, "A kept", int'(a_out), a);
            check(req, "flags kept", int'({n_out, z_out, c_out, v_out}),
                  fl_n * 8 + fl_z * 4 + cf * 2 + fl_v);
        end else begin
            check(req, "result A", int'(a_out), res);
            check("R2", "carry", int'(c_out), int'(diff >= 0));
            check("R3", "negative", int'(n_out), int'(res >= 128));
            check("R3", "zero", int'(z_out), int'(res == 0));
            check("R4", "overflow", int'(v_out), int'(sres < -128 || sres > 127));
        end
        check(req, "read count", rd_log.size(), exp_reads.size());
        for (int i = 0; i < exp_reads.size() && i < rd_log.size(); i++)
            check(req, "read address", rd_log[i], exp_reads[i]);
        @(negedge clk);
        check("R10", "done pulse ends", int'(done), 0);
        check("R10", "A holds after done", int'(a_out), bad ? a : res);
    endtask

    // Place a program of up to four bytes
    task automatic put4(input int addr, input int b0, input int b1, input int b2, input int b3);
        mem[addr] = 8'(b0); mem[(addr + 1) % 65536] = 8'(b1);
        mem[(addr + 2) % 65536] = 8'(b2); mem[(addr + 3) % 65536] = 8'(b3);
    endtask

    // The three arithmetic vectors applied through one mode
    task automatic three_vectors(input string req, input int opc, input int b1, input int b2,
                                 input int eff, input int x, input int y);
        int avals [3] = '{'h00, 'h7F, 'hC0};
        int mvals [3] = '{'h01, 'hFF, 'h40};
        int cvals [3] = '{1, 1, 0};
        for (int k = 0; k < 3; k++) begin
            mem.delete();
            put4('h0200, opc, b1, b2, 0);
            if (opc == 'hE9) mem['h0201] = 8'(mvals[k]);
            else mem[eff] = 8'(mvals[k]);
            run_case(req, 'h0200, avals[k], x, y, cvals[k], 0, 1, 0, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11", "done in reset", int'(done), 0);
        check("R11", "illegal in reset", int'(illegal), 0);
        check("R11", "rd_en in reset", int'(mem_rd_en), 0);
        check("R11", "A in reset", int'(a_out), 0);
        check("R11", "flags in reset", int'({n_out, z_out, c_out, v_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "idle without start", int'(mem_rd_en), 0);

        // R5 immediate
        three_vectors("R5", 'hE9, 0, 0, 0, 0, 0);
        // R6 zero page and zero page plus X
        three_vectors("R6", 'hE5, 'h40, 0, 'h40, 0, 0);
        three_vectors("R6", 'hF5, 'h40, 0, 'h45, 5, 0);
        // R7 absolute and indexed absolute
        three_vectors("R7", 'hED, 'h34, 'h12, 'h1234, 0, 0);
        three_vectors("R7", 'hFD, 'h34, 'h12, 'h1236, 2, 0);
        three_vectors("R7", 'hF9, 'h34, 'h12, 'h1237, 0, 3);
        // R8 indexed-indirect by X: pointer at 0x12 -> 0x4567
        for (int k = 0; k < 2; k++) begin
            mem.delete();
            put4('h0200, 'hE1, 'h10, 0, 0);
            mem['h12] = 8'h67; mem['h13] = 8'h45; mem['h4567] = (k == 0) ? 8'h01 : 8'h40;
            run_case("R8", 'h0200, (k == 0) ? 'h00 : 'hC0, 2, 0, 1 - k, 0, 0, 0, 1'b0);
        end
        // R9 indirect-indexed by Y: pointer at 0x20 -> 0x30F0, plus Y crosses a page
        mem.delete();
        put4('h0200, 'hF1, 'h20, 0, 0);
        mem['h20] = 8'hF0; mem['h21] = 8'h30; mem['h3110] = 8'hFF;
        run_case("R9", 'h0200, 'h7F, 0, 'h20, 1, 0, 0, 0, 1'b0);

        // R6 wrap: 0xFF + X = 0x01
        mem.delete();
        put4('h0200, 'hF5, 'hFF, 0, 0); mem['h01] = 8'h40;
        run_case("R6", 'h0200, 'h40, 2, 0, 1, 0, 0, 0, 1'b0);
        // R7 wrap: 0xFFFF + X = 0x0003
        mem.delete();
        put4('h0200, 'hFD, 'hFF, 'hFF, 0); mem['h0003] = 8'h10;
        run_case("R7", 'h0200, 'h05, 4, 0, 0, 0, 0, 0, 1'b0);
        // R8 wrap: pointer low at 0xFF, high at 0x00
        mem.delete();
        put4('h0200, 'hE1, 'hFD, 0, 0);
        mem['hFF] = 8'h22; mem['h00] = 8'h11; mem['h1122] = 8'h80;
        run_case("R8", 'h0200, 'h00, 2, 0, 1, 0, 0, 0, 1'b0);
        // R9 wrap: pointer at 0xFF/0x00 and Y sum past 0xFFFF
        mem.delete();
        put4('h0200, 'hF1, 'hFF, 0, 0);
        mem['hFF] = 8'hFE; mem['h00] = 8'hFF; mem['h0001] = 8'h7F;
        run_case("R9", 'h0200, 'h80, 0, 3, 0, 1, 0, 0, 1'b0);

        // R3 zero result
        mem.delete();
        put4('h0200, 'hE9, 'h40, 0, 0);
        run_case("R3", 'h0200, 'h40, 0, 0, 1, 1, 0, 1, 1'b0);

        // R1 unsupported opcodes leave registers as given
        mem.delete();
        put4('h0200, 'h69, 'h01, 0, 0);
        run_case("R1", 'h0200, 'h5A, 1, 2, 1, 1, 0, 1, 1'b0);
        mem.delete();
        put4('h0200, 'hEA, 'h01, 0, 0);
        run_case("R1", 'h0200, 'hA5, 0, 0, 0, 0, 1, 0, 1'b0);

        // R10 second start and changed inputs during a running instruction
        mem.delete();
        put4('h0200, 'hFD, 'h00, 'h40, 0); mem['h4003] = 8'h11;
        mem['h0300] = 8'hE9; mem['h0301] = 8'h99;
        run_case("R10", 'h0200, 'h50, 3, 0, 1, 0, 0, 0, 1'b1);
        mem.delete();
        put4('h0200, 'hF1, 'h30, 0, 0);
        mem['h30] = 8'h00; mem['h31] = 8'h50; mem['h5004] = 8'h01;
        mem['h0300] = 8'hE9; mem['h0301] = 8'h99;
        run_case("R10", 'h0200, 'h10, 0, 4, 0, 0, 0, 0, 1'b1);
        @(negedge clk);
        check("R10", "no restart after poke", int'(mem_rd_en), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule